// File: doc/BRIEF.md
# Parallel Slave Data Port

This block lets an external microprocessor treat an 8-bit port as a plain bus peripheral. The external side drives active-low chip-select, read and write strobes at any time, with no relation to the internal clock. It writes a byte into an inbound latch, or it reads a byte from an outbound latch. On the internal side, a local host loads the outbound latch and reads the inbound latch through one shared register location. Status flags tell the host whether each buffer is full and whether an inbound byte was overwritten before the host read it. An interrupt flag marks the end of each external transfer.

The strobes pass through two-flop synchronizers. A transfer starts when chip-select and the matching strobe are both seen low in the synchronized domain. It ends when either of them returns high. Completion is reported a fixed number of internal cycles after the synchronized release. While port mode is off, the external strobes have no effect and the data bus enable follows an ordinary direction input.

Top module: `pps_port`

## Requirements
- R1: During and right after reset, `in_full`, `out_full`, `ovf` and `irq_flag` are 0 and `ext_data_out` is 0.
- R2: An external write (chip-select and write both low, then either released) loads the byte on `ext_data_in` into the inbound latch (`host_rdata`) and sets `in_full` and `irq_flag` on the same edge. That edge is the 5th rising clock edge after the release is applied, which is SYNC_STAGES + DONE_DELAY + 1 with the defaults 2 and 2.
- R3: `in_full` clears on the edge where `host_rd_in` is high. If that edge is also the one where an external write completes, `in_full` is set, not cleared, and the host read returns the byte held before that edge.
- R4: An external write that completes while `in_full` is already 1 sets `ovf` and overwrites the inbound latch. `ovf` stays 1, even with port mode off, until an edge with `ovf_clr` high.
- R5: When chip-select and read are both driven low, `out_full` goes to 0 on the 3rd rising edge, which is SYNC_STAGES + 1.
- R6: When an external read is released, `irq_flag` is set on the 5th rising edge after the release. `out_full` stays 0 until the host writes the outbound latch.
- R7: A `host_wr_out` pulse loads `host_wdata` into `ext_data_out` on that edge and, with port mode on, sets `out_full`. A host write on the same edge as a read start wins. `ext_data_out` does not change on any other edge.
- R8: While `mode_en` is 0, `in_full` and `out_full` read 0. External strobes then change neither the flags nor the inbound latch, and `ovf` keeps its value.
- R9: With `mode_en` at 1, `ext_data_oe` is 1 exactly while `ext_cs_n` and `ext_rd_n` are both low, with no clock delay. With `mode_en` at 0, `ext_data_oe` equals `dir_out`.
- R10: `irq_flag` stays set until an edge with `irq_clr` high. `irq` is 1 only when both `irq_flag` and `irq_en` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Port mode enable |
| dir_out | input | 1 | Bus drive enable used when port mode is off |
| ext_cs_n | input | 1 | External chip-select, active low |
| ext_rd_n | input | 1 | External read strobe, active low |
| ext_wr_n | input | 1 | External write strobe, active low |
| ext_data_in | input | 8 | Byte from the external bus |
| ext_data_out | output | 8 | Outbound latch driven toward the bus |
| ext_data_oe | output | 1 | Bus output enable |
| host_wr_out | input | 1 | Host write pulse for the outbound latch |
| host_wdata | input | 8 | Host write data |
| host_rd_in | input | 1 | Host read pulse for the inbound latch |
| host_rdata | output | 8 | Inbound latch contents |
| ovf_clr | input | 1 | Clears the overflow flag |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq_en | input | 1 | Interrupt enable |
| in_full | output | 1 | Inbound buffer full |
| out_full | output | 1 | Outbound buffer full |
| ovf | output | 1 | Sticky inbound overflow |
| irq_flag | output | 1 | Transfer-complete interrupt flag |
| irq | output | 1 | Gated interrupt request |

## Verification
Single external writes with distinct bytes, each read back by the host, show that the byte is captured from the bus and that completion lands on the fifth edge. A second write before the host reads shows the overflow path and that the newer byte wins. A write whose completion lands on the same edge as a host read shows that the set has priority. External reads preceded by a host load check the immediate clear of `out_full` separately from the delayed interrupt. The disabled-mode pattern separates the cleared buffer flags from the retained overflow flag and from the bus enable driven by `dir_out`.

// File: rtl/pps_pkg.sv
package pps_pkg;
    localparam int PPS_DW = 8;

    typedef struct packed {
        logic [PPS_DW-1:0] in_lat;
        logic [PPS_DW-1:0] out_lat;
        logic [PPS_DW-1:0] stage;
        logic              in_full;
        logic              out_full;
        logic              ovf;
        logic              irq_flag;
    } pps_state_t;
endpackage

// File: rtl/pps_sync.sv
module pps_sync #(
    parameter int   WIDTH   = 3,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= {WIDTH{RST_VAL}};
                else if (g == 0) chain_q[g] <= async_i;
                else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pps_xfer_detect.sv
module pps_xfer_detect #(
    parameter int DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    output logic start,
    output logic done
);
    logic act_q;
    logic fall;
    logic [DELAY-1:0] pipe_q;

    assign start = act & ~act_q;
    assign fall  = ~act & act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= 1'b0;
        else act_q <= act;
    end

    generate
        if (DELAY == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else pipe_q <= fall;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else pipe_q <= {pipe_q[DELAY-2:0], fall};
            end
        end
    endgenerate

    assign done = pipe_q[DELAY-1];
endmodule

// File: rtl/pps_port.sv
module pps_port
    import pps_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DONE_DELAY  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic              dir_out,
    input  logic              ext_cs_n,
    input  logic              ext_rd_n,
    input  logic              ext_wr_n,
    input  logic [PPS_DW-1:0] ext_data_in,
    output logic [PPS_DW-1:0] ext_data_out,
    output logic              ext_data_oe,
    input  logic              host_wr_out,
    input  logic [PPS_DW-1:0] host_wdata,
    input  logic              host_rd_in,
    output logic [PPS_DW-1:0] host_rdata,
    input  logic              ovf_clr,
    input  logic              irq_clr,
    input  logic              irq_en,
    output logic              in_full,
    output logic              out_full,
    output logic              ovf,
    output logic              irq_flag,
    output logic              irq
);
    localparam int STROBES = 3;

    pps_state_t st_d, st_q;
    logic [STROBES-1:0] strb_s;
    logic cs_s, rd_s, wr_s;
    logic act_wr, act_rd;
    logic wr_start, wr_done, rd_start, rd_done;

    pps_sync #(.WIDTH(STROBES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ext_cs_n, ext_rd_n, ext_wr_n}),
        .sync_o  (strb_s)
    );

    assign {cs_s, rd_s, wr_s} = strb_s;
    assign act_wr = mode_en & ~cs_s & ~wr_s;
    assign act_rd = mode_en & ~cs_s & ~rd_s;

    pps_xfer_detect #(.DELAY(DONE_DELAY)) u_wr_det (
        .clk(clk), .rst_n(rst_n), .act(act_wr), .start(wr_start), .done(wr_done)
    );

    pps_xfer_detect #(.DELAY(DONE_DELAY)) u_rd_det (
        .clk(clk), .rst_n(rst_n), .act(act_rd), .start(rd_start), .done(rd_done)
    );

    always_comb begin
        st_d = st_q;
        // sample bus while the synchronized write is active
        if (act_wr) st_d.stage = ext_data_in;
        // clears first, sets afterwards so sets win
        if (host_rd_in) st_d.in_full  = 1'b0;
        if (ovf_clr)    st_d.ovf      = 1'b0;
        if (irq_clr)    st_d.irq_flag = 1'b0;
        if (rd_start)   st_d.out_full = 1'b0;
        if (host_wr_out) begin
            st_d.out_lat  = host_wdata;
            st_d.out_full = 1'b1;
        end
        if (wr_done) begin
            st_d.in_lat   = st_q.stage;
            st_d.in_full  = 1'b1;
            st_d.irq_flag = 1'b1;
            if (st_q.in_full) st_d.ovf = 1'b1;
        end
        if (rd_done) st_d.irq_flag = 1'b1;
        if (!mode_en) begin
            st_d.in_full  = 1'b0;
            st_d.out_full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else st_q <= st_d;
    end

    assign ext_data_out = st_q.out_lat;
    assign host_rdata   = st_q.in_lat;
    assign in_full      = st_q.in_full;
    assign out_full     = st_q.out_full;
    assign ovf          = st_q.ovf;
    assign irq_flag     = st_q.irq_flag;
    assign irq          = st_q.irq_flag & irq_en;
    assign ext_data_oe  = mode_en ? (~ext_cs_n & ~ext_rd_n) : dir_out;
endmodule

// File: rtl/pps_port_sva.sv
module pps_port_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_en,
    input logic       host_wr_out,
    input logic       host_rd_in,
    input logic       ovf_clr,
    input logic       irq_clr,
    input logic [7:0] ext_data_out,
    input logic       in_full,
    input logic       out_full,
    input logic       ovf,
    input logic       irq_flag
);
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_clear: assert (!in_full && !out_full && !ovf && !irq_flag
                                      && ext_data_out == 8'h00);
        end
    end

    a_r2_flags_together: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_full) |-> irq_flag);

    a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (in_full && !host_rd_in && mode_en) |=> in_full);

    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    a_r7_host_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_out && mode_en) |=> out_full);

    a_r7_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr_out |=> $stable(ext_data_out));

    a_r8_mode_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> (!in_full && !out_full));

    a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);
endmodule

bind pps_port pps_port_sva u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_en      (mode_en),
    .host_wr_out  (host_wr_out),
    .host_rd_in   (host_rd_in),
    .ovf_clr      (ovf_clr),
    .irq_clr      (irq_clr),
    .ext_data_out (ext_data_out),
    .in_full      (in_full),
    .out_full     (out_full),
    .ovf          (ovf),
    .irq_flag     (irq_flag)
);

// File: tb/pps_port_bench.sv
`timescale 1ns/1ps
module pps_port_bench;
    localparam int LAT_DONE  = 5;
    localparam int LAT_START = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_en = 1'b0, dir_out = 1'b0;
    logic ext_cs_n = 1'b1, ext_rd_n = 1'b1, ext_wr_n = 1'b1;
    logic [7:0] ext_data_in = 8'h00, host_wdata = 8'h00;
    logic host_wr_out = 1'b0, host_rd_in = 1'b0;
    logic ovf_clr = 1'b0, irq_clr = 1'b0, irq_en = 1'b0;
    logic [7:0] ext_data_out, host_rdata;
    logic ext_data_oe, in_full, out_full, ovf, irq_flag, irq;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    pps_port u_pps_port (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .dir_out(dir_out),
        .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
        .ext_data_in(ext_data_in), .ext_data_out(ext_data_out),
        .ext_data_oe(ext_data_oe), .host_wr_out(host_wr_out),
        .host_wdata(host_wdata), .host_rd_in(host_rd_in),
        .host_rdata(host_rdata), .ovf_clr(ovf_clr), .irq_clr(irq_clr),
        .irq_en(irq_en), .in_full(in_full), .out_full(out_full), .ovf(ovf),
        .irq_flag(irq_flag), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: scoreboard pops on every host read of the inbound latch
    always begin
        @(negedge clk);
        #1;
        if (host_rd_in) begin
            if (exp_q.size() == 0) chk(1'b0, "R2 scoreboard empty", host_rdata, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(host_rdata == e, "R2 host read byte", host_rdata, e);
            end
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic host_read();
        @(negedge clk); host_rd_in = 1'b1;
        @(negedge clk); host_rd_in = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk); host_wr_out = 1'b1; host_wdata = d;
        @(negedge clk); host_wr_out = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic ext_write(input logic [7:0] d, input bit push, input bit collide);
        int lat;
        clear_irq();
        if (push) exp_q.push_back(d);
        @(negedge clk); ext_data_in = d; ext_cs_n = 1'b0; ext_wr_n = 1'b0;
        tick(4);
        ext_cs_n = 1'b1; ext_wr_n = 1'b1;
        lat = 0;
        for (int n = 1; n <= 12; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (host_rd_in) host_rd_in = 1'b0;
            if (collide && n == LAT_DONE - 1) host_rd_in = 1'b1;
            if (irq_flag && lat == 0) lat = n;
        end
        chk(lat == LAT_DONE, "R2 write completion latency", lat, LAT_DONE);
        chk(in_full == 1'b1, "R2 in_full set with irq", in_full, 1);
    endtask

    task automatic ext_read();
        int lat;
        clear_irq();
        @(negedge clk); ext_cs_n = 1'b0; ext_rd_n = 1'b0;
        #0.5;
        chk(ext_data_oe == 1'b1, "R9 oe follows strobes at once", ext_data_oe, 1);
        lat = 0;
        for (int n = 1; n <= 5; n++) begin
            @(posedge clk); @(negedge clk);
            if (!out_full && lat == 0) lat = n;
        end
        chk(lat == LAT_START, "R5 out_full clear latency", lat, LAT_START);
        ext_cs_n = 1'b1; ext_rd_n = 1'b1;
        #0.5;
        chk(ext_data_oe == 1'b0, "R9 oe drops on release", ext_data_oe, 0);
        lat = 0;
        for (int n = 1; n <= 10; n++) begin
            @(posedge clk); @(negedge clk);
            if (irq_flag && lat == 0) lat = n;
        end
        chk(lat == LAT_DONE, "R6 read completion latency", lat, LAT_DONE);
        chk(out_full == 1'b0, "R6 out_full stays low", out_full, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        chk({in_full, out_full, ovf, irq_flag} == 4'b0, "R1 flags in reset",
            {in_full, out_full, ovf, irq_flag}, 0);
        rst_n = 1'b1;
        tick(2);
        chk({in_full, out_full, ovf, irq_flag} == 4'b0 && ext_data_out == 8'h00,
            "R1 flags after reset", {in_full, out_full, ovf, irq_flag}, 0);

        // R9 disabled mode: oe follows dir_out
        dir_out = 1'b1; #0.5;
        chk(ext_data_oe == 1'b1, "R9 oe equals dir_out high", ext_data_oe, 1);
        dir_out = 1'b0; #0.5;
        chk(ext_data_oe == 1'b0, "R9 oe equals dir_out low", ext_data_oe, 0);

        mode_en = 1'b1;
        tick(2);

        // R7 host write
        host_write(8'hA5);
        chk(out_full == 1'b1, "R7 out_full set", out_full, 1);
        chk(ext_data_out == 8'hA5, "R7 outbound byte", ext_data_out, 8'hA5);

        // R5 R6 external read
        ext_read();
        chk(ext_data_out == 8'hA5, "R7 outbound byte unchanged by read", ext_data_out, 8'hA5);

        // R10 gating and clear
        chk(irq == 1'b0, "R10 irq masked", irq, 0);
        irq_en = 1'b1; #0.5;
        chk(irq == 1'b1, "R10 irq enabled", irq, 1);
        tick(3);
        chk(irq_flag == 1'b1, "R10 flag holds", irq_flag, 1);
        clear_irq();
        chk(irq_flag == 1'b0 && irq == 1'b0, "R10 flag cleared", irq_flag, 0);
        irq_en = 1'b0;

        // R2 R3 single writes
        ext_write(8'h3C, 1'b1, 1'b0);
        host_read();
        chk(in_full == 1'b0, "R3 in_full cleared by host read", in_full, 1'b0);
        ext_write(8'hC3, 1'b1, 1'b0);
        host_read();
        chk(ovf == 1'b0, "R4 no overflow on read-before-write", ovf, 0);

        // R4 overflow
        ext_write(8'h11, 1'b0, 1'b0);
        ext_write(8'h22, 1'b1, 1'b0);
        chk(ovf == 1'b1, "R4 overflow set", ovf, 1);
        host_read();
        tick(3);
        chk(ovf == 1'b1, "R4 overflow sticky", ovf, 1);

        // R8 disabled mode keeps ovf, clears buffers, ignores strobes
        host_write(8'h5A);
        clear_irq();
        @(negedge clk); mode_en = 1'b0;
        tick(2);
        chk(out_full == 1'b0, "R8 out_full held clear", out_full, 0);
        chk(ovf == 1'b1, "R8 ovf kept with mode off", ovf, 1);
        ext_data_in = 8'hEE; ext_cs_n = 1'b0; ext_wr_n = 1'b0;
        tick(4);
        ext_cs_n = 1'b1; ext_wr_n = 1'b1;
        tick(10);
        chk(irq_flag == 1'b0 && in_full == 1'b0, "R8 strobes ignored",
            {irq_flag, in_full}, 0);
        chk(host_rdata == 8'h22, "R8 inbound latch untouched", host_rdata, 8'h22);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        chk(ovf == 1'b0, "R4 ovf cleared by host", ovf, 0);
        mode_en = 1'b1;
        tick(2);

        // R3 collision: host read on the completion edge
        ext_write(8'h44, 1'b1, 1'b0);
        ext_write(8'h55, 1'b1, 1'b1);
        chk(in_full == 1'b1, "R3 set wins over host read", in_full, 1);
        chk(host_rdata == 8'h55, "R3 new byte latched", host_rdata, 8'h55);
        host_read();
        tick(2);
        chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule